// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Lock Bits

This block holds a set of translation entries, each made of a tag word and a translation-entry word. Bit 63 of the entry word marks the entry valid, and bit 6 marks it locked. A small register file sits beside the array. Register 6 of that file is the tag-staging register: every entry write takes its tag from it.

The block accepts one command per cycle on `req_i`/`cmd_i`, together with an address and a 64-bit data word. There are three entry operations. A replacement write lets the block choose the victim entry. A direct write places the entry at an index taken from address bits 8:3. An associative lookup returns the tag of the first valid entry whose tag equals the presented word.

Replacement prefers the lowest-numbered invalid entry. If every entry is valid, it falls back to the lowest-numbered unlocked entry. If every entry is both valid and locked, the write is dropped and an error strobe is raised. Register reads and lookups answer one cycle after the command, with `rvalid_o` high for that one cycle.

Top module: `tlb_assoc`

## Requirements
- R1: After reset every entry is invalid and every register reads as zero.
- R2: Command 0 (register read) and command 1 (register write) select one of 16 registers by address bits 6:3. A read answers on `rdata_o` with `rvalid_o` high in the cycle after the command. A write is visible to a command in the following cycle.
- R3: Command 3 (direct write) writes entry `addr_i[8:3]`. It takes its tag from register 6 and its entry word from `wdata_i`.
- R4: Command 4 (lookup) compares `wdata_i` with every entry tag. When some valid entry matches, `rdata_o` carries that entry's tag in the next cycle, with `rvalid_o` high.
- R5: A lookup that matches no valid entry returns zero. An entry whose bit 63 is clear never matches, even if its tag is equal.
- R6: Command 2 (replacement write) takes its tag from register 6 and its word from `wdata_i`. It writes the lowest-numbered entry whose bit 63 is clear.
- R7: When every entry is valid, a replacement write goes to the lowest-numbered entry whose bit 6 is clear.
- R8: When every entry is valid and locked, a replacement write changes no entry. `err_o` is high for exactly the one cycle after that command.
- R9: Command codes 5 to 7 change no register and no entry, and they raise neither `rvalid_o` nor `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Command code (0 reg read, 1 reg write, 2 replace, 3 direct write, 4 lookup) |
| addr_i | input | ADDR_W (16) | Address; bits 6:3 pick a register, bits 8:3 pick an entry |
| wdata_i | input | 64 | Write data, or the lookup key |
| rvalid_o | output | 1 | Read or lookup answer valid |
| rdata_o | output | 64 | Read or lookup answer |
| err_o | output | 1 | Replacement dropped because every entry is locked |

## Verification
The assertions check on every cycle that the outputs have a cause:
- `rvalid_o` only follows a read or a lookup.
- `err_o` only follows a replacement.
- A lookup miss yields zero.
- The replacement victim really is invalid whenever an invalid entry exists.
- Every priority pick is one-hot and lies inside its request vector.

Which entry a replacement actually overwrote, the fallback to unlocked entries, and the dropping of a write into a fully locked array can only be shown by the bench's scenarios. They probe these through later lookups.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [2:0] {
    CMD_REG_RD  = 3'd0,
    CMD_REG_WR  = 3'd1,
    CMD_REPL_WR = 3'd2,
    CMD_DIR_WR  = 3'd3,
    CMD_TAG_RD  = 3'd4
  } tlb_cmd_e;
endpackage

// File: rtl/tlb_first_set.sv
module tlb_first_set #(
  parameter int N = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             found_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
    found_o = |req_i;
    gnt_o   = found_o ? (N'(1) << idx_o) : '0;
  end

  // R6/R7: a pick is one-hot and lies inside its request vector
  always_comb begin
    if (!$isunknown(req_i)) begin
      a_r7_pick_legal: assert ($onehot0(gnt_o) && ((gnt_o & ~req_i) == '0));
    end
  end
endmodule

// File: rtl/tlb_regfile.sv
module tlb_regfile #(
  parameter int NREGS   = 16,
  parameter int W       = 64,
  parameter int TAG_REG = 6,
  localparam int SEL_W  = $clog2(NREGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] wsel_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [SEL_W-1:0] rsel_i,
  output logic [W-1:0]     rdata_o,
  output logic [W-1:0]     tag_o
);
  logic [NREGS-1:0][W-1:0] regs_q;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            regs_q[g] <= '0;
      else if (we_i && wsel_i == SEL_W'(g))   regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[rsel_i];
  assign tag_o   = regs_q[TAG_REG];
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int N         = 64,
  parameter int W         = 64,
  parameter int VALID_BIT = 63,
  parameter int LOCK_BIT  = 6,
  localparam int IDX_W    = $clog2(N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [IDX_W-1:0]    widx_i,
  input  logic [W-1:0]        wtag_i,
  input  logic [W-1:0]        wword_i,
  input  logic [W-1:0]        key_i,
  output logic [N-1:0]        valid_o,
  output logic [N-1:0]        lock_o,
  output logic [N-1:0]        match_o,
  output logic [N-1:0][W-1:0] tags_o
);
  logic [N-1:0][W-1:0] tag_q;
  logic [N-1:0][W-1:0] word_q;
  logic [N-1:0]        unused_word_par;

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q[g]  <= '0;
        word_q[g] <= '0;
      end else if (we_i && widx_i == IDX_W'(g)) begin
        tag_q[g]  <= wtag_i;
        word_q[g] <= wword_i;
      end
    end
    assign valid_o[g]         = word_q[g][VALID_BIT];
    assign lock_o[g]          = word_q[g][LOCK_BIT];
    assign match_o[g]         = valid_o[g] && (tag_q[g] == key_i);
    assign unused_word_par[g] = ^word_q[g];
  end

  assign tags_o = tag_q;
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
  import tlb_pkg::*;
#(
  parameter int ENTRIES   = 64,
  parameter int W         = 64,
  parameter int NREGS     = 16,
  parameter int TAG_REG   = 6,
  parameter int VALID_BIT = 63,
  parameter int LOCK_BIT  = 6,
  parameter int SEL_LSB   = 3,
  parameter int ADDR_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic              rvalid_o,
  output logic [W-1:0]      rdata_o,
  output logic              err_o
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int SEL_W = $clog2(NREGS);

  logic do_reg_rd, do_reg_wr, do_repl, do_dir, do_tag_rd;
  assign do_reg_rd = req_i && cmd_i == CMD_REG_RD;
  assign do_reg_wr = req_i && cmd_i == CMD_REG_WR;
  assign do_repl   = req_i && cmd_i == CMD_REPL_WR;
  assign do_dir    = req_i && cmd_i == CMD_DIR_WR;
  assign do_tag_rd = req_i && cmd_i == CMD_TAG_RD;

  logic [SEL_W-1:0] reg_sel;
  logic [IDX_W-1:0] ent_sel;
  logic             unused_addr;
  assign reg_sel     = addr_i[SEL_LSB +: SEL_W];
  assign ent_sel     = addr_i[SEL_LSB +: IDX_W];
  assign unused_addr = ^addr_i;

  logic [W-1:0] rf_rdata, staged_tag;

  tlb_regfile #(.NREGS(NREGS), .W(W), .TAG_REG(TAG_REG)) u_regs (
    .clk_i, .rst_ni,
    .we_i   (do_reg_wr),
    .wsel_i (reg_sel),
    .wdata_i(wdata_i),
    .rsel_i (reg_sel),
    .rdata_o(rf_rdata),
    .tag_o  (staged_tag)
  );

  logic [ENTRIES-1:0]        ent_valid, ent_lock, ent_match;
  logic [ENTRIES-1:0][W-1:0] ent_tags;
  logic                      arr_we;
  logic [IDX_W-1:0]          arr_idx;

  tlb_entry_array #(
    .N(ENTRIES), .W(W), .VALID_BIT(VALID_BIT), .LOCK_BIT(LOCK_BIT)
  ) u_array (
    .clk_i, .rst_ni,
    .we_i   (arr_we),
    .widx_i (arr_idx),
    .wtag_i (staged_tag),
    .wword_i(wdata_i),
    .key_i  (wdata_i),
    .valid_o(ent_valid),
    .lock_o (ent_lock),
    .match_o(ent_match),
    .tags_o (ent_tags)
  );

  logic [ENTRIES-1:0] inv_gnt, unl_gnt, hit_gnt;
  logic [IDX_W-1:0]   inv_idx, unl_idx, hit_idx;
  logic               inv_found, unl_found, hit_found;

  tlb_first_set #(.N(ENTRIES)) u_pick_inv (
    .req_i(~ent_valid), .gnt_o(inv_gnt), .idx_o(inv_idx), .found_o(inv_found));
  tlb_first_set #(.N(ENTRIES)) u_pick_unl (
    .req_i(~ent_lock),  .gnt_o(unl_gnt), .idx_o(unl_idx), .found_o(unl_found));
  tlb_first_set #(.N(ENTRIES)) u_pick_hit (
    .req_i(ent_match),  .gnt_o(hit_gnt), .idx_o(hit_idx), .found_o(hit_found));

  logic             unused_gnt;
  logic [IDX_W-1:0] repl_idx;
  logic             repl_ok;
  assign unused_gnt = ^{inv_gnt, unl_gnt, hit_gnt};
  assign repl_idx   = inv_found ? inv_idx : unl_idx;
  assign repl_ok    = inv_found || unl_found;
  assign arr_we     = do_dir || (do_repl && repl_ok);
  assign arr_idx    = do_dir ? ent_sel : repl_idx;

  logic         rvalid_q, err_q;
  logic [W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= do_reg_rd || do_tag_rd;
      err_q    <= do_repl && !repl_ok;
      if (do_reg_rd)      rdata_q <= rf_rdata;
      else if (do_tag_rd) rdata_q <= hit_found ? ent_tags[hit_idx] : '0;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
  assign err_o    = err_q;

  a_r2_rvalid_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && (cmd_i == CMD_REG_RD || cmd_i == CMD_TAG_RD)));

  a_r8_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i && cmd_i == CMD_REPL_WR));

  a_r5_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && cmd_i == CMD_TAG_RD && ent_match == '0) |=> (rdata_o == '0));

  a_r6_victim_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_repl && inv_found) |-> !ent_valid[arr_idx]);
endmodule

// File: tb/tlb_assoc_test.sv
module tlb_assoc_test;
  localparam time CLK_P = 20ns;
  localparam logic [63:0] VLD = 64'h8000_0000_0000_0000;
  localparam logic [63:0] LCK = 64'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  cmd = '0;
  logic [15:0] addr = '0;
  logic [63:0] wdata = '0;
  logic        rvalid, err;
  logic [63:0] rdata;

  int checks = 0;
  int errors = 0;
  logic        l_rvalid, l_err;
  logic [63:0] l_rdata;

  always #(CLK_P / 2) clk = ~clk;

  tlb_assoc uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cmd_i(cmd), .addr_i(addr),
    .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata), .err_o(err)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(logic [2:0] c, logic [15:0] a, logic [63:0] d);
    @(negedge clk);
    req = 1'b1; cmd = c; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    l_rvalid = rvalid; l_rdata = rdata; l_err = err;
  endtask

  task automatic set_tag(logic [63:0] t);
    op(3'd1, 16'(6 << 3), t);
  endtask

  task automatic dir_wr(int idx, logic [63:0] t, logic [63:0] w);
    set_tag(t);
    op(3'd3, 16'(idx << 3), w);
  endtask

  task automatic lookup(string tag, logic [63:0] key, logic [63:0] exp);
    op(3'd4, '0, key);
    chk({tag, " rvalid"}, 64'(l_rvalid), 64'd1);
    chk(tag, l_rdata, exp);
  endtask

  task automatic t_reset;
    op(3'd0, 16'(6 << 3), '0);
    chk("R1 reg6 after reset", l_rdata, 64'd0);
    op(3'd0, 16'(15 << 3), '0);
    chk("R1 reg15 after reset", l_rdata, 64'd0);
    lookup("R1 lookup after reset", 64'd0, 64'd0);
  endtask

  task automatic t_regs;
    op(3'd1, 16'(3 << 3), 64'hDEAD_BEEF_0000_0003);
    op(3'd1, 16'(12 << 3), 64'h1234_5678_9ABC_DEF0);
    chk("R2 rvalid low after write", 64'(l_rvalid), 64'd0);
    op(3'd0, 16'(3 << 3), '0);
    chk("R2 rvalid", 64'(l_rvalid), 64'd1);
    chk("R2 reg3", l_rdata, 64'hDEAD_BEEF_0000_0003);
    op(3'd0, 16'(12 << 3), '0);
    chk("R2 reg12", l_rdata, 64'h1234_5678_9ABC_DEF0);
  endtask

  task automatic t_replace_invalid;
    set_tag(64'hA0);
    op(3'd2, '0, VLD);
    chk("R6 no err", 64'(l_err), 64'd0);
    set_tag(64'hB0);
    op(3'd2, '0, VLD);
    lookup("R6 tag A0 placed", 64'hA0, 64'hA0);
    lookup("R6 tag B0 placed", 64'hB0, 64'hB0);
    // invalidate entry 0, replacement must reuse it
    dir_wr(0, 64'hEE, 64'h0);
    lookup("R5 invalid entry misses", 64'hEE, 64'd0);
    set_tag(64'hC0);
    op(3'd2, '0, VLD);
    dir_wr(0, 64'hD0, VLD);
    lookup("R6 C0 was in entry 0", 64'hC0, 64'd0);
    lookup("R6 B0 kept in entry 1", 64'hB0, 64'hB0);
    lookup("R3 direct D0", 64'hD0, 64'hD0);
  endtask

  task automatic t_lookup;
    lookup("R5 miss", 64'h5555, 64'd0);
    dir_wr(7, 64'h77, VLD | 64'h123);
    dir_wr(9, 64'h77, VLD);
    lookup("R4 dup tag hit", 64'h77, 64'h77);
    dir_wr(7, 64'h78, VLD);
    dir_wr(9, 64'h79, VLD);
    lookup("R4 overwrite frees old tag", 64'h77, 64'd0);
  endtask

  task automatic t_locked;
    for (int i = 0; i < 64; i++) begin
      if (i == 5 || i == 9) dir_wr(i, 64'(256 + i), VLD);
      else                  dir_wr(i, 64'(256 + i), VLD | LCK);
    end
    set_tag(64'h999);
    op(3'd2, '0, VLD | LCK);
    chk("R7 no err", 64'(l_err), 64'd0);
    lookup("R7 new tag present", 64'h999, 64'h999);
    lookup("R7 entry 5 replaced", 64'(256 + 5), 64'd0);
    lookup("R7 entry 9 kept", 64'(256 + 9), 64'(256 + 9));
    lookup("R7 entry 4 kept", 64'(256 + 4), 64'(256 + 4));
  endtask

  task automatic t_all_locked;
    dir_wr(9, 64'(256 + 9), VLD | LCK);
    set_tag(64'h777);
    op(3'd2, '0, VLD);
    chk("R8 err pulse", 64'(l_err), 64'd1);
    @(negedge clk);
    chk("R8 err one cycle", 64'(err), 64'd0);
    lookup("R8 dropped", 64'h777, 64'd0);
    lookup("R8 entry 9 intact", 64'(256 + 9), 64'(256 + 9));
    lookup("R8 entry 0 intact", 64'(256), 64'(256));
  endtask

  task automatic t_undefined;
    set_tag(64'h42);
    for (int c = 5; c < 8; c++) begin
      op(3'(c), 16'(6 << 3), 64'hBAD);
      chk("R9 no rvalid", 64'(l_rvalid), 64'd0);
      chk("R9 no err", 64'(l_err), 64'd0);
    end
    op(3'd0, 16'(6 << 3), '0);
    chk("R9 reg6 unchanged", l_rdata, 64'h42);
    lookup("R9 no entry written", 64'h42, 64'd0);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_replace_invalid();
    t_lookup();
    t_locked();
    t_all_locked();
    t_undefined();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule